// File: doc/BRIEF.md
# Page Column Pointer for a Small-Page NAND Device

This block is the device-side pointer logic that tracks the column within one 528-byte page of an x8 small-page NAND array. A page is split into three areas of unequal size: a lower data half (columns 0..255), an upper data half (columns 256..511) and a 16-byte spare tail (columns 512..527). The upper column bits are not sent as address bits. Instead, a pointer command picks the area, and the first address byte then gives the offset inside that area.

Once the start column has been loaded, each data strobe moves the column forward by one. This holds whether the byte is being read out or loaded in. The column crosses area boundaries freely until it reaches the last byte of the page. There it stops and raises an end-of-page flag. The pointer chosen by the upper-half command lasts for a single operation. The other two pointers stay in force until another pointer command arrives.

The command and address bytes come into the block already latched. All outputs are registered and change one clock after the strobe that causes the change.

Top module: `page_col_ptr`

## Requirements
- R1: After a synchronous reset, `column` is 0, `end_of_page` is 0 and `area` is 0 (lower half).
- R2: Command 8'h00 sets `area` to 0 and command 8'h50 sets `area` to 2 (spare). Both settings survive an `op_done` pulse.
- R3: Command 8'h01 sets `area` to 1 (upper half). The first `op_done` after it returns `area` to 0, one clock after the pulse.
- R4: Any other command byte on `cmd_valid` leaves `area`, `column` and `end_of_page` unchanged.
- R5: An `addr_valid` strobe loads `column` with the area base plus `addr_byte`. The base is 0 for area 0 and 256 for area 1. The same strobe clears `end_of_page`.
- R6: When `area` is 2, an address load uses only `addr_byte[3:0]`, so `column` = 512 + `addr_byte[3:0]`.
- R7: Each `data_strobe` below column 527 advances `column` by exactly one, crossing 255→256 and 511→512 with no wrap.
- R8: A `data_strobe` at column 527 sets `end_of_page` and leaves `column` at 527. Later strobes change neither output.
- R9: When `addr_valid` and `data_strobe` arrive in the same cycle, the address load wins.
- R10: `column` never exceeds 527.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe: `cmd_byte` holds a latched command |
| cmd_byte | input | 8 | Command byte |
| addr_valid | input | 1 | Strobe: `addr_byte` is the first address byte |
| addr_byte | input | 8 | First address byte (offset within the area) |
| data_strobe | input | 1 | One pulse per data byte transferred |
| op_done | input | 1 | Pulse at the end of a read or program operation |
| column | output | 10 | Current page column |
| end_of_page | output | 1 | Set once the strobe past the last column has been seen |
| area | output | 2 | Selected area: 0 lower, 1 upper, 2 spare |

## Verification
The main path is exercised from a table. Each row is a pointer command, a start byte and a number of strobes. The rows together cover every area, start offsets at area edges and strobe counts that cross the 255/256 and 511/512 boundaries. Spare-area starts use address bytes with set upper bits, which separates masking from plain addition. Rows that run past column 527 separate saturation from wrap. Checking `area` after `op_done` on each row separates the one-shot pointer from the persistent ones. Directed tests then cover unknown commands, a collision between an address load and a strobe, strobes after end of page, and reset in the middle of an operation.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  typedef enum logic [1:0] {
    AREA_LO    = 2'd0,
    AREA_HI    = 2'd1,
    AREA_SPARE = 2'd2
  } area_t;

  localparam logic [7:0] CMD_PTR_LO    = 8'h00;
  localparam logic [7:0] CMD_PTR_HI    = 8'h01;
  localparam logic [7:0] CMD_PTR_SPARE = 8'h50;
endpackage

// File: rtl/pcp_area_sel.sv
module pcp_area_sel
  import pcp_pkg::*;
#(
  parameter logic [7:0] CMD_LO    = CMD_PTR_LO,
  parameter logic [7:0] CMD_HI    = CMD_PTR_HI,
  parameter logic [7:0] CMD_SPARE = CMD_PTR_SPARE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       op_done,
  output area_t      area_q
);
  logic one_shot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      area_q     <= AREA_LO;
      one_shot_q <= 1'b0;
    end else if (cmd_valid) begin
      if (cmd_byte == CMD_LO) begin
        area_q     <= AREA_LO;
        one_shot_q <= 1'b0;
      end else if (cmd_byte == CMD_HI) begin
        area_q     <= AREA_HI;
        one_shot_q <= 1'b1;
      end else if (cmd_byte == CMD_SPARE) begin
        area_q     <= AREA_SPARE;
        one_shot_q <= 1'b0;
      end
    end else if (op_done && one_shot_q) begin
      area_q     <= AREA_LO;
      one_shot_q <= 1'b0;
    end
  end

  // R3: the one-shot upper pointer falls back after an operation
  p_hi_reverts_r3: assert property (@(posedge clk) disable iff (rst)
    (area_q == AREA_HI && op_done && !cmd_valid) |=> (area_q == AREA_LO));

  // R2: the persistent pointers ignore op_done
  p_persist_r2: assert property (@(posedge clk) disable iff (rst)
    (area_q != AREA_HI && !cmd_valid) |=> $stable(area_q));

  // area never takes the unused code
  p_area_legal_r2: assert property (@(posedge clk) disable iff (rst)
    area_q != 2'd3);
endmodule

// File: rtl/pcp_col_count.sv
module pcp_col_count
  import pcp_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  localparam int PAGE_BYTES = 2 * HALF_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int OFS_W      = $clog2(HALF_BYTES),
  localparam int SP_W       = $clog2(SPARE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  area_t            area,
  input  logic             addr_valid,
  input  logic [OFS_W-1:0] addr_byte,
  input  logic             data_strobe,
  output logic [COL_W-1:0] col_q,
  output logic             eop_q
);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] BASE_HI    = COL_W'(HALF_BYTES);
  localparam logic [COL_W-1:0] BASE_SPARE = COL_W'(2 * HALF_BYTES);

  logic [COL_W-1:0] load_col;

  always_comb begin
    unique case (area)
      AREA_HI:    load_col = BASE_HI + COL_W'(addr_byte);
      AREA_SPARE: load_col = BASE_SPARE + COL_W'(addr_byte[SP_W-1:0]);
      default:    load_col = COL_W'(addr_byte);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      eop_q <= 1'b0;
    end else if (addr_valid) begin
      col_q <= load_col;
      eop_q <= 1'b0;
    end else if (data_strobe && !eop_q) begin
      if (col_q == LAST_COL) eop_q <= 1'b1;
      else                   col_q <= col_q + 1'b1;
    end
  end

  // R10: column stays inside the page
  p_col_range_r10: assert property (@(posedge clk) disable iff (rst)
    col_q <= LAST_COL);

  // R8: end of page is sticky and pins the column at the last byte
  p_eop_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (eop_q && !addr_valid) |=> (eop_q && col_q == LAST_COL));

  // R7: a strobe below the last column advances by one
  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    (data_strobe && !addr_valid && !eop_q && col_q != LAST_COL)
      |=> (col_q == $past(col_q) + 1'b1) && !eop_q);

  // R6: a spare-area load lands inside the spare tail
  p_spare_load_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && area == AREA_SPARE) |=> (col_q >= BASE_SPARE && !eop_q));

  // R5: a load clears the end-of-page flag
  p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !eop_q);
endmodule

// File: rtl/page_col_ptr.sv
module page_col_ptr
  import pcp_pkg::*;
#(
  parameter int HALF_BYTES  = 256,
  parameter int SPARE_BYTES = 16,
  parameter logic [7:0] CMD_LO    = CMD_PTR_LO,
  parameter logic [7:0] CMD_HI    = CMD_PTR_HI,
  parameter logic [7:0] CMD_SPARE = CMD_PTR_SPARE,
  localparam int COL_W = $clog2(2 * HALF_BYTES + SPARE_BYTES),
  localparam int OFS_W = $clog2(HALF_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_valid,
  input  logic [OFS_W-1:0] addr_byte,
  input  logic             data_strobe,
  input  logic             op_done,
  output logic [COL_W-1:0] column,
  output logic             end_of_page,
  output logic [1:0]       area
);
  area_t area_w;

  pcp_area_sel #(
    .CMD_LO(CMD_LO), .CMD_HI(CMD_HI), .CMD_SPARE(CMD_SPARE)
  ) u_sel (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .op_done(op_done), .area_q(area_w)
  );

  pcp_col_count #(
    .HALF_BYTES(HALF_BYTES), .SPARE_BYTES(SPARE_BYTES)
  ) u_cnt (
    .clk(clk), .rst(rst), .area(area_w), .addr_valid(addr_valid),
    .addr_byte(addr_byte), .data_strobe(data_strobe),
    .col_q(column), .eop_q(end_of_page)
  );

  assign area = area_w;

  // R4: a non-pointer command touches nothing
  p_unknown_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte != CMD_LO && cmd_byte != CMD_HI &&
     cmd_byte != CMD_SPARE && !addr_valid && !data_strobe)
      |=> ($stable(area) && $stable(column) && $stable(end_of_page)));
endmodule

// File: tb/tb_page_col_ptr.sv
`timescale 1ns/1ps
module tb_page_col_ptr;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       addr_valid = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic       data_strobe = 1'b0;
  logic       op_done = 1'b0;
  logic [9:0] column;
  logic       end_of_page;
  logic [1:0] area;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  page_col_ptr dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .data_strobe(data_strobe),
    .op_done(op_done), .column(column), .end_of_page(end_of_page), .area(area)
  );

  // cmd, start byte, strobes, expected column, eop, area after op_done
  localparam int NV = 8;
  localparam logic [7:0] V_CMD  [NV] = '{8'h00, 8'h01, 8'h50, 8'h00, 8'h50, 8'h01, 8'h00, 8'h50};
  localparam logic [7:0] V_ADDR [NV] = '{8'h10, 8'hFE, 8'hF3, 8'hFF, 8'h0F, 8'hFF, 8'hFC, 8'h05};
  localparam int         V_NSTR [NV] = '{5, 3, 2, 1, 1, 1, 0, 11};
  localparam int         V_COL  [NV] = '{21, 513, 517, 256, 527, 512, 252, 527};
  localparam logic       V_EOP  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int         V_AREA [NV] = '{0, 0, 2, 0, 2, 0, 0, 2};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = c;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] a);
    @(negedge clk); addr_valid = 1'b1; addr_byte = a;
    @(negedge clk); addr_valid = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_strobe = 1'b1;
    end
    @(negedge clk); data_strobe = 1'b0;
  endtask

  task automatic finish_op();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 column", column, 0);
    check("R1 eop", end_of_page, 0);
    check("R1 area", area, 0);

    // table walk: R2 R3 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      send_cmd(V_CMD[v]);
      send_addr(V_ADDR[v]);
      if (V_NSTR[v] > 0) strobes(V_NSTR[v]);
      check("R5/R6/R7/R8 column", column, V_COL[v]);
      check("R8 eop", end_of_page, V_EOP[v]);
      finish_op();
      check("R2/R3 area after op_done", area, V_AREA[v]);
    end

    // R3: upper pointer visible before op_done, gone after
    send_cmd(8'h01);
    check("R3 area set", area, 1);
    finish_op();
    check("R3 area reverted", area, 0);

    // R4: unknown command leaves everything
    send_cmd(8'h50);
    send_addr(8'h02);
    send_cmd(8'h90);
    check("R4 area", area, 2);
    check("R4 column", column, 514);
    check("R4 eop", end_of_page, 0);

    // R8: strobes after end of page change nothing; R10 range
    strobes(30);
    check("R8 eop set", end_of_page, 1);
    check("R10 column capped", column, 527);
    strobes(4);
    check("R8 column held", column, 527);
    // R5: new load clears eop
    send_cmd(8'h00);
    send_addr(8'h80);
    check("R5 eop cleared", end_of_page, 0);
    check("R5 column", column, 128);

    // R9: load and strobe together, load wins
    @(negedge clk); addr_valid = 1'b1; addr_byte = 8'h40; data_strobe = 1'b1;
    @(negedge clk); addr_valid = 1'b0; data_strobe = 1'b0;
    check("R9 column", column, 64);

    // R1: reset mid-operation
    send_cmd(8'h50);
    send_addr(8'h0F);
    strobes(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 column after reset", column, 0);
    check("R1 eop after reset", end_of_page, 0);
    check("R1 area after reset", area, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule